// File: doc/BRIEF.md
# DAC Data-Hold and Trigger Controller

This block is the digital front end of a single 12-bit digital-to-analog converter channel. Software writes a sample word into a holding register over a small write-only register bus. The block then copies that word into the output code register that feeds the converter. Full scale is code 4095, so the analog level equals the reference voltage times the code divided by 4095. The copy can happen at once, or it can wait for a selected trigger event.

When triggering is enabled, a 3-bit source select picks the event. Seven codes pick hardware event inputs, such as timer trigger outputs or an external interrupt line. The eighth code picks a software trigger bit. Hardware inputs are synchronized, and only a rising edge counts. After an event is accepted, the transfer completes after a fixed three-cycle latency. The value loaded is the holding register content at the moment of the load. Only one transfer can be in flight at a time. The software trigger bit clears itself when its load completes.

The register bus uses a valid/ready handshake. `bus_ready` is held high at all times, so the block never applies back-pressure: every cycle in which `bus_valid` is high is an accepted write.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `sw_trig_o` is 0, triggering is disabled, the source select is 0 and the holding register is 0.
- R2: `bus_ready` is always 1. Address 0 is the control word: bit 0 is the trigger enable and bits 3:1 are the source select. Address 1 writes `bus_wdata[11:0]` into the holding register; upper bits are discarded. Address 2 with bit 0 = 1 sets the software trigger bit; writing 0 there has no effect. Address 3 changes nothing.
- R3: With trigger enable at 0, `dac_code` takes the holding register value one clock after the write is accepted. It keeps following the holding register every cycle.
- R4: With trigger enable at 1, `dac_code` holds its value and ignores holding register writes until a trigger transfer completes.
- R5: Select codes 0 to 6 choose `hw_trig_i[code]`. Code 7 chooses the software trigger bit. Events on inputs that are not selected cause no transfer.
- R6: Each hardware input passes through a two-flop synchronizer, and only a rising edge starts a transfer. A level held high, or a falling edge, starts nothing further.
- R7: If a selected input rises before clock edge P0, `dac_code` is unchanged after P4 and shows the new value after P5. This is the edge detection plus three cycles of transfer latency.
- R8: The word loaded is the holding register content at the load edge, including a write accepted while the transfer was pending.
- R9: With code 7 selected, a software trigger write accepted at edge W loads `dac_code` at edge W+4, and `sw_trig_o` clears at that same edge. If the software source is not selected, the bit stays set. A new set request in the load cycle takes priority over the clear.
- R10: An event that arrives while a transfer is pending is dropped and never produces a second load.
- R11: Changing the source select while a transfer is pending does not cancel that transfer.
- R12: A trigger edge seen while the enable is 0 is lost and produces no load after the enable returns to 1. Clearing the enable drops any pending transfer, and pass-through resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Write request valid |
| bus_ready | output | 1 | Write ready, constant 1 |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| hw_trig_i | input | 7 | Hardware trigger event inputs, asynchronous |
| dac_code | output | 12 | Output code register driving the converter |
| sw_trig_o | output | 1 | Current state of the software trigger bit |

## Verification
The bound checker watches these on every cycle:
- pass-through while disabled;
- that `dac_code` stays still while enabled and idle;
- that the pending counter steps down one per cycle within its range;
- the holding-register value being taken at the load edge;
- the self-clear of the software bit;
- the reset values.

Only the bench scenarios can show the following:
- the end-to-end latency from an asynchronous input change through the synchronizer;
- that unselected inputs, held levels and falling edges are ignored;
- that a second event during a pending transfer is dropped;
- that edges seen while disabled never come back.

The bench sweeps every hardware source code with several data patterns and then runs the software and corner scenarios.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  localparam int unsigned BUS_ADDR_W = 2;

  typedef enum logic [BUS_ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_DATA   = 2'd1,
    REG_SWTRIG = 2'd2,
    REG_SPARE  = 2'd3
  } reg_addr_e;

  // Position of the enable bit in the control word; select follows it.
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SEL_LSB = 1;

endpackage

// File: rtl/dac_trig_regs.sv
module dac_trig_regs
  import dac_trig_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned BUS_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [BUS_ADDR_W-1:0] wr_addr,
  input  logic [BUS_DATA_W-1:0] wr_data,
  input  logic                  sw_clr,
  output logic                  ctrl_en,
  output logic [SEL_W-1:0]      ctrl_sel,
  output logic [DATA_W-1:0]     hold_q,
  output logic                  sw_q,
  output logic                  sw_set
);

  logic wr_ctrl;
  logic wr_data_reg;
  logic wr_sw;
  logic unused_wdata_bits;

  always_comb begin
    wr_ctrl     = wr_fire && (reg_addr_e'(wr_addr) == REG_CTRL);
    wr_data_reg = wr_fire && (reg_addr_e'(wr_addr) == REG_DATA);
    wr_sw       = wr_fire && (reg_addr_e'(wr_addr) == REG_SWTRIG);
    sw_set      = wr_sw && wr_data[0];
  end

  // Bits of the write word that no register field uses.
  assign unused_wdata_bits = ^wr_data[BUS_DATA_W-1:SEL_W+CTRL_SEL_LSB] ^
                             ^wr_data[BUS_DATA_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_sel <= '0;
    end else if (wr_ctrl) begin
      ctrl_en  <= wr_data[CTRL_EN_BIT];
      ctrl_sel <= wr_data[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_data_reg) begin
      hold_q <= wr_data[DATA_W-1:0];
    end
  end

  // A set request wins over the hardware clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
    end else if (sw_set) begin
      sw_q <= 1'b1;
    end else if (sw_clr) begin
      sw_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dac_trig_edge.sv
module dac_trig_edge #(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] trig_async,
  output logic [N_SRC-1:0] trig_rise
);

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      logic [SYNC_N-1:0] sync_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[SYNC_N-2:0], trig_async[g]};
          prev_q <= sync_q[SYNC_N-1];
        end
      end

      assign trig_rise[g] = sync_q[SYNC_N-1] && !prev_q;
    end
  endgenerate

endmodule

// File: rtl/dac_trig_xfer.sv
module dac_trig_xfer #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned N_HW   = 7,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned LAT    = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_HW-1:0]   hw_rise,
  input  logic              sw_bit,
  input  logic [DATA_W-1:0] hold,
  output logic [DATA_W-1:0] dor_q,
  output logic              pending_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              from_sw_q,
  output logic              sw_done
);

  localparam logic [SEL_W-1:0] SEL_SW   = SEL_W'(N_HW);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LAT - 1);

  logic hw_hit;
  logic sw_hit;
  logic start;
  logic load;

  always_comb begin
    hw_hit = 1'b0;
    for (int i = 0; i < N_HW; i++) begin
      if (sel == SEL_W'(i)) hw_hit = hw_rise[i];
    end
    sw_hit  = (sel == SEL_SW) && sw_bit;
    start   = en && !pending_q && (hw_hit || sw_hit);
    load    = en && pending_q && (cnt_q == '0);
    sw_done = load && from_sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
      from_sw_q <= 1'b0;
    end else if (!en) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
      from_sw_q <= 1'b0;
    end else if (start) begin
      pending_q <= 1'b1;
      cnt_q     <= CNT_INIT;
      from_sw_q <= sw_hit;
    end else if (load) begin
      pending_q <= 1'b0;
      from_sw_q <= 1'b0;
    end else if (pending_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dor_q <= '0;
    end else if (!en || load) begin
      dor_q <= hold;
    end
  end

endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned N_HW       = 7,
  parameter int unsigned LAT        = 3,
  parameter int unsigned BUS_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  output logic                  bus_ready,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  input  logic [N_HW-1:0]       hw_trig_i,
  output logic [DATA_W-1:0]     dac_code,
  output logic                  sw_trig_o
);

  localparam int unsigned SEL_W = $clog2(N_HW + 1);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic              ctrl_en;
  logic [SEL_W-1:0]  ctrl_sel;
  logic [DATA_W-1:0] hold_q;
  logic              sw_q;
  logic              sw_set_req;
  logic              sw_done;
  logic [N_HW-1:0]   hw_rise;
  logic              xfer_pending;
  logic [CNT_W-1:0]  xfer_cnt;
  logic              xfer_from_sw;

  assign bus_ready = 1'b1;

  dac_trig_regs #(
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .BUS_DATA_W (BUS_DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (bus_valid && bus_ready),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .sw_clr   (sw_done),
    .ctrl_en  (ctrl_en),
    .ctrl_sel (ctrl_sel),
    .hold_q   (hold_q),
    .sw_q     (sw_q),
    .sw_set   (sw_set_req)
  );

  dac_trig_edge #(
    .N_SRC  (N_HW),
    .SYNC_N (2)
  ) edge_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_async (hw_trig_i),
    .trig_rise  (hw_rise)
  );

  dac_trig_xfer #(
    .DATA_W (DATA_W),
    .N_HW   (N_HW),
    .SEL_W  (SEL_W),
    .LAT    (LAT),
    .CNT_W  (CNT_W)
  ) xfer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .sel       (ctrl_sel),
    .hw_rise   (hw_rise),
    .sw_bit    (sw_q),
    .hold      (hold_q),
    .dor_q     (dac_code),
    .pending_q (xfer_pending),
    .cnt_q     (xfer_cnt),
    .from_sw_q (xfer_from_sw),
    .sw_done   (sw_done)
  );

  assign sw_trig_o = sw_q;

endmodule

// File: rtl/dac_trig_ctrl_chk.sv
module dac_trig_ctrl_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LAT    = 3,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [DATA_W-1:0] hold,
  input logic [DATA_W-1:0] dac_code,
  input logic              pending,
  input logic [CNT_W-1:0]  cnt,
  input logic              from_sw,
  input logic              sw_bit,
  input logic              sw_set
);

  // R1: reset returns outputs to zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (dac_code == '0 && !sw_bit));

  // R3: pass-through while triggering is disabled
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dac_code == $past(hold)));

  // R4: enabled and idle keeps the output code still
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pending) |=> $stable(dac_code));

  // R7: countdown steps by one and keeps the transfer pending
  a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pending && cnt != '0) |=> (pending && cnt == $past(cnt) - CNT_W'(1)));

  // R7: counter never exceeds the latency window
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (int'(cnt) <= int'(LAT) - 1));

  // R8: load takes the holding value at the load edge and ends the transfer
  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pending && cnt == '0) |=> (dac_code == $past(hold) && !pending));

  // R9: software bit clears with its own load unless set again
  a_r9_sw_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pending && from_sw && cnt == '0 && !sw_set) |=> !sw_bit);

endmodule

bind dac_trig_ctrl dac_trig_ctrl_chk #(
  .DATA_W (DATA_W),
  .LAT    (LAT),
  .CNT_W  (CNT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (ctrl_en),
  .hold     (hold_q),
  .dac_code (dac_code),
  .pending  (xfer_pending),
  .cnt      (xfer_cnt),
  .from_sw  (xfer_from_sw),
  .sw_bit   (sw_q),
  .sw_set   (sw_set_req)
);

// File: tb/dac_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_trig_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [6:0]  hw_trig_i = '0;
  logic [11:0] dac_code;
  logic        sw_trig_o;

  int checks = 0;
  int failures = 0;
  logic [11:0] exp_code;

  always #2 clk = ~clk;

  dac_trig_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_trig_i (hw_trig_i),
    .dac_code  (dac_code),
    .sw_trig_o (sw_trig_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; write accepted at the next posedge; returns at the following negedge.
  task automatic wr(input int addr, input int data);
    bus_valid = 1'b1;
    bus_addr  = 2'(addr);
    bus_wdata = 16'(data);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctrl_word(input int sel, input int en);
    return (sel << 1) | en;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 dac_code", dac_code, 0);
    check("R1 sw_trig", sw_trig_o, 0);
    check("R2 ready", bus_ready, 1);

    // R3 pass-through timing
    wr(1, 'h5A5);
    check("R3 before", dac_code, 0);
    idle(1);
    check("R3 after", dac_code, 'h5A5);

    // R2 spare address and upper bits
    wr(3, 'h0FF);
    idle(3);
    check("R2 spare addr", dac_code, 'h5A5);
    wr(1, 'hF123);
    idle(1);
    check("R2 upper bits", dac_code, 'h123);
    exp_code = 12'h123;

    // Sweep of all hardware sources (R4 R5 R6 R7)
    for (int sel = 0; sel < 7; sel++) begin
      wr(0, ctrl_word(sel, 1));
      for (int k = 0; k < 3; k++) begin
        logic [11:0] v;
        int other;
        v = (k == 0) ? 12'(sel * 'h249) : (k == 1) ? 12'('hFFF - sel) : 12'('h800 | sel);
        other = (sel + 1) % 7;
        wr(1, v);
        idle(4);
        check("R4 held while enabled", dac_code, exp_code);
        hw_trig_i[other] = 1'b1;
        idle(2);
        hw_trig_i[other] = 1'b0;
        idle(8);
        check("R5 unselected ignored", dac_code, exp_code);
        hw_trig_i[sel] = 1'b1;
        idle(5);
        check("R7 not before P5", dac_code, exp_code);
        idle(1);
        check("R7 loaded at P5", dac_code, v);
        exp_code = v;
        wr(1, v ^ 12'hFFF);
        idle(8);
        check("R6 level ignored", dac_code, exp_code);
        hw_trig_i[sel] = 1'b0;
        idle(8);
        check("R6 falling ignored", dac_code, exp_code);
      end
    end

    // R8 value at load time
    wr(0, ctrl_word(2, 1));
    wr(1, 'h111);
    hw_trig_i[2] = 1'b1;
    idle(3);
    wr(1, 'h222);
    idle(1);
    check("R8 before load", dac_code, exp_code);
    idle(1);
    check("R8 late write loaded", dac_code, 'h222);
    hw_trig_i[2] = 1'b0;
    idle(4);

    // R11 select change while pending
    wr(1, 'h333);
    hw_trig_i[2] = 1'b1;
    idle(3);
    wr(0, ctrl_word(5, 1));
    idle(1);
    check("R11 before load", dac_code, 'h222);
    idle(1);
    check("R11 transfer kept", dac_code, 'h333);
    hw_trig_i[2] = 1'b0;
    idle(4);

    // R10 second edge while pending
    wr(1, 'h444);
    hw_trig_i[5] = 1'b1;
    idle(1);
    hw_trig_i[5] = 1'b0;
    idle(1);
    hw_trig_i[5] = 1'b1;
    idle(1);
    hw_trig_i[5] = 1'b0;
    idle(2);
    check("R10 before load", dac_code, 'h333);
    idle(1);
    check("R10 first load", dac_code, 'h444);
    wr(1, 'h555);
    idle(10);
    check("R10 no second load", dac_code, 'h444);

    // R9 software trigger
    wr(0, ctrl_word(7, 1));
    wr(2, 1);
    check("R9 bit set", sw_trig_o, 1);
    idle(3);
    check("R9 before load", dac_code, 'h444);
    check("R9 bit still set", sw_trig_o, 1);
    idle(1);
    check("R9 loaded at W+4", dac_code, 'h555);
    check("R9 bit cleared", sw_trig_o, 0);

    // R2 writing 0 does not clear; R9 bit persists when not selected
    wr(0, ctrl_word(1, 1));
    wr(2, 1);
    wr(2, 0);
    check("R2 zero write no effect", sw_trig_o, 1);
    wr(1, 'h666);
    idle(6);
    check("R9 not selected no load", dac_code, 'h555);
    check("R9 bit persists", sw_trig_o, 1);
    wr(0, ctrl_word(7, 1));
    idle(3);
    check("R9 before deferred load", dac_code, 'h555);
    idle(1);
    check("R9 deferred load", dac_code, 'h666);
    check("R9 deferred clear", sw_trig_o, 0);

    // R12 edge while disabled is lost
    wr(0, ctrl_word(3, 0));
    hw_trig_i[3] = 1'b1;
    idle(6);
    hw_trig_i[3] = 1'b0;
    wr(0, ctrl_word(3, 1));
    wr(1, 'h777);
    idle(8);
    check("R12 no late load", dac_code, 'h666);
    wr(0, ctrl_word(3, 0));
    idle(1);
    check("R12 pass-through resumes", dac_code, 'h777);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule